// File: doc/BRIEF.md
# PLL Divider Chain

This block holds the three digital dividers that sit around a phase-locked loop in a frequency synthesizer. A fixed prescaler divides the reference clock by eight and emits a single-cycle pulse toward the phase detector. A programmable feedback counter divides the VCO clock by a 9-bit ratio and marks each terminal count with a one-cycle pulse, which is the loop's feedback event. A power-of-two output divider turns the VCO clock into the synthesizer's output clock, with a choice of four ratios and an even duty cycle for each.

The ratios come from a configuration register outside the block. That register may be loaded over either a serial path or a parallel path. A ratio change never takes effect part way through a division period. A new feedback ratio waits for the terminal count. A new output ratio waits until the output divider's phase counter returns to zero. The loop therefore never sees a short or stretched period, and the output never glitches.

Top module: `synth_div_chain`

## Requirements
- R1: The reference pulse is high for exactly one reference-clock cycle out of every eight. After reset it first appears once seven reference edges have passed with reset low.
- R2: The feedback pulse is high for exactly one VCO cycle at the terminal count. Pulses are spaced by the effective ratio. After reset the first pulse appears once the effective ratio minus one VCO edges have passed with reset low.
- R3: The effective feedback ratio equals the 9-bit ratio input, except that an input of 0 or 1 is divided as 2.
- R4: A ratio input that changes mid-period leaves the period in progress unchanged. The new ratio is captured at the clock edge that ends a terminal-count cycle.
- R5: The 2-bit output select encodes 0 as divide by 2, 1 as divide by 4, 2 as divide by 8 and 3 as divide by 16. For each setting the output is high for exactly half of each period.
- R6: The output divider uses a free-running 4-bit phase. The output equals the phase bit picked by the current select. A changed select is adopted only on the edge where the phase wraps from 15 to 0, and the output is low whenever the phase is 0.
- R7: Reset is synchronous and active high. During reset all three outputs are low, all counters are zero, and the feedback ratio and output select are loaded from the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | VCO clock; drives the feedback and output dividers |
| ref_clk | input | 1 | Reference oscillator clock; drives the prescaler |
| rst | input | 1 | Synchronous active-high reset, held over edges of both clocks |
| m_cfg | input | 9 | Feedback division ratio from the configuration register |
| n_cfg | input | 2 | Output ratio select (0:/2, 1:/4, 2:/8, 3:/16) |
| ref_pulse | output | 1 | Divided-reference pulse toward the phase detector |
| fb_pulse | output | 1 | Feedback terminal-count pulse toward the phase detector |
| clk_out | output | 1 | Divided output clock |

## Verification
The assertions take for granted that reset stays high across at least one edge of each clock. They also assume the ratio and select inputs are synchronous to the VCO clock, so they never change close to a VCO edge. The stimulus drives reset, ratio and select two nanoseconds after a VCO rising edge. The reference clock is set to a period that keeps its edges on odd nanoseconds, well clear of those changes. Ratio updates are issued at terminal counts and also part way through periods. Select updates land at arbitrary phases of the 16-cycle frame.

// File: rtl/div_chain_pkg.sv
package div_chain_pkg;

    localparam int unsigned M_WIDTH     = 9;
    localparam int unsigned PRE_LOG2    = 3;
    localparam int unsigned SEL_WIDTH   = 2;
    localparam int unsigned PHASE_WIDTH = 1 << SEL_WIDTH;

    typedef enum logic [SEL_WIDTH-1:0] {
        RATIO_2  = 2'd0,
        RATIO_4  = 2'd1,
        RATIO_8  = 2'd2,
        RATIO_16 = 2'd3
    } ratio_e;

    typedef struct packed {
        logic [PHASE_WIDTH-1:0] phase;
        ratio_e                 sel;
        logic                   level;
    } out_state_t;

    function automatic ratio_e to_ratio(input logic [SEL_WIDTH-1:0] code);
        return ratio_e'(code);
    endfunction

endpackage

// File: rtl/ref_prescaler.sv
module ref_prescaler #(
    parameter int unsigned LOG2 = 3
) (
    input  logic clk,
    input  logic rst,
    output logic pulse
);
    localparam logic [LOG2-1:0] LAST = {LOG2{1'b1}};

    logic [LOG2-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign pulse = (cnt_q == LAST);
endmodule

// File: rtl/fb_divider.sv
module fb_divider #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ratio,
    output logic         tc_pulse
);
    localparam logic [W-1:0] FLOOR = W'(2);

    logic [W-1:0] cnt_q;
    logic [W-1:0] limit_q;
    logic [W-1:0] ratio_eff;
    logic         at_tc;

    assign ratio_eff = (ratio < FLOOR) ? FLOOR : ratio;
    assign at_tc     = (cnt_q == limit_q - W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            limit_q <= ratio_eff;
        end else if (at_tc) begin
            cnt_q   <= '0;
            limit_q <= ratio_eff;
        end else begin
            cnt_q   <= cnt_q + W'(1);
        end
    end

    assign tc_pulse = at_tc;
endmodule

// File: rtl/out_divider.sv
module out_divider
    import div_chain_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SEL_WIDTH-1:0] sel_in,
    output logic                 clk_div
);
    out_state_t st_q;
    out_state_t st_d;

    always_comb begin
        st_d.phase = st_q.phase + 1'b1;
        st_d.sel   = (st_q.phase == '1) ? to_ratio(sel_in) : st_q.sel;
        st_d.level = st_d.phase[st_d.sel];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= '0;
            st_q.sel   <= to_ratio(sel_in);
            st_q.level <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_div = st_q.level;
endmodule

// File: rtl/synth_div_chain.sv
module synth_div_chain
    import div_chain_pkg::*;
#(
    parameter int unsigned M_W      = M_WIDTH,
    parameter int unsigned PRE_BITS = PRE_LOG2
) (
    input  logic                 vco_clk,
    input  logic                 ref_clk,
    input  logic                 rst,
    input  logic [M_W-1:0]       m_cfg,
    input  logic [SEL_WIDTH-1:0] n_cfg,
    output logic                 ref_pulse,
    output logic                 fb_pulse,
    output logic                 clk_out
);

    ref_prescaler #(.LOG2(PRE_BITS)) u_pre (
        .clk   (ref_clk),
        .rst   (rst),
        .pulse (ref_pulse)
    );

    fb_divider #(.W(M_W)) u_fb (
        .clk      (vco_clk),
        .rst      (rst),
        .ratio    (m_cfg),
        .tc_pulse (fb_pulse)
    );

    out_divider u_out (
        .clk     (vco_clk),
        .rst     (rst),
        .sel_in  (n_cfg),
        .clk_div (clk_out)
    );

endmodule

// File: rtl/div_chain_checker.sv
module div_chain_checker
    import div_chain_pkg::*;
#(
    parameter int unsigned M_W      = M_WIDTH,
    parameter int unsigned PRE_BITS = PRE_LOG2
) (
    input logic                   vco_clk,
    input logic                   ref_clk,
    input logic                   rst,
    input logic                   ref_pulse,
    input logic                   fb_pulse,
    input logic                   clk_out,
    input logic [M_W-1:0]         fb_limit,
    input logic [PHASE_WIDTH-1:0] out_phase,
    input logic [SEL_WIDTH-1:0]   out_sel
);
    localparam int unsigned GAP_W = PRE_BITS + 1;
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'((1 << PRE_BITS) - 1);

    logic [GAP_W-1:0] gap_q;
    logic             armed_q;

    always_ff @(posedge ref_clk) begin
        if (rst)            gap_q <= '0;
        else if (ref_pulse) gap_q <= '0;
        else                gap_q <= gap_q + 1'b1;
    end

    always_ff @(posedge vco_clk) begin
        armed_q <= !rst;
    end

    // R1: reference pulse exactly when the checker's own gap counter reaches seven
    a_r1_ref_spacing: assert property (@(posedge ref_clk) disable iff (rst)
        ref_pulse == (gap_q == GAP_LAST));

    // R2: feedback pulse lasts one VCO cycle
    a_r2_fb_one_cycle: assert property (@(posedge vco_clk) disable iff (rst)
        fb_pulse |=> !fb_pulse);

    // R3: loaded ratio never below two
    a_r3_limit_floor: assert property (@(posedge vco_clk) disable iff (rst)
        fb_limit >= M_W'(2));

    // R4: loaded ratio changes only after a terminal-count cycle
    a_r4_limit_at_tc: assert property (@(posedge vco_clk) disable iff (rst)
        (armed_q && !$stable(fb_limit)) |-> $past(fb_pulse));

    // R6: select changes only as the phase wraps to zero
    a_r6_sel_at_wrap: assert property (@(posedge vco_clk) disable iff (rst)
        (armed_q && !$stable(out_sel)) |-> (out_phase == '0));

    // R6: output low at the start of each frame
    a_r6_low_at_frame: assert property (@(posedge vco_clk) disable iff (rst)
        (out_phase == '0) |-> !clk_out);

endmodule

bind synth_div_chain div_chain_checker #(.M_W(M_W), .PRE_BITS(PRE_BITS)) u_chk (
    .vco_clk   (vco_clk),
    .ref_clk   (ref_clk),
    .rst       (rst),
    .ref_pulse (ref_pulse),
    .fb_pulse  (fb_pulse),
    .clk_out   (clk_out),
    .fb_limit  (u_fb.limit_q),
    .out_phase (u_out.st_q.phase),
    .out_sel   (u_out.st_q.sel)
);

// File: tb/synth_div_chain_bench.sv
module synth_div_chain_bench;

    logic       vco_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       rst     = 1'b1;
    logic [8:0] m_cfg   = 9'd5;
    logic [1:0] n_cfg   = 2'd0;
    logic       ref_pulse, fb_pulse, clk_out;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;
    bit done   = 1'b0;

    int t  = 0;
    int rt = 0;
    int esel = 0;

    int fbq[$];
    int last_tc = 0;
    int cur_eff = 0;

    synth_div_chain u_synth_div_chain (
        .vco_clk(vco_clk), .ref_clk(ref_clk), .rst(rst),
        .m_cfg(m_cfg), .n_cfg(n_cfg),
        .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .clk_out(clk_out)
    );

    always #4 vco_clk = ~vco_clk;   // 125 MHz
    always #9 ref_clk = ~ref_clk;

    // edge counters since reset, and expected output select per R5/R6
    always @(posedge vco_clk) begin
        t <= rst ? 0 : t + 1;
        if (rst)               esel <= int'(n_cfg);
        else if (t % 16 == 15) esel <= int'(n_cfg);
    end

    always @(posedge ref_clk) rt <= rst ? 0 : rt + 1;

    function automatic int eff(input int m);
        return (m < 2) ? 2 : m;   // R3
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at t=%0d: actual=%0d expected=%0d", req, t, act, exp);
        end
    endtask

    // driver: change the ratio at a chosen offset after the last terminal count
    task automatic drive_m(input int m, input int k, input int delay);
        while (t != last_tc + delay) begin
            @(posedge vco_clk); #2;
        end
        m_cfg = 9'(m);
        if (delay > 0) begin           // R4: period in progress keeps the old ratio
            last_tc += cur_eff;
            fbq.push_back(last_tc);
        end
        cur_eff = eff(m);
        for (int i = 0; i < k; i++) begin
            last_tc += cur_eff;
            fbq.push_back(last_tc);
        end
    endtask

    // monitor: feedback pulses against the scoreboard queue (R2, R3, R4)
    always @(negedge vco_clk) begin
        if (mon_on && !done) begin
            if (fbq.size() > 0 && fbq[0] == t) begin
                check(fb_pulse == 1'b1, "R2/R4 fb pulse due", int'(fb_pulse), 1);
                void'(fbq.pop_front());
            end else if (fb_pulse) begin
                check(1'b0, "R2/R4 unexpected fb pulse", 1, 0);
            end
            // R5, R6: output equals the selected bit of the frame phase
            check(clk_out == (((t % 16) >> esel) & 1), "R5/R6 clk_out",
                  int'(clk_out), ((t % 16) >> esel) & 1);
        end
    end

    // monitor: reference pulse (R1)
    always @(negedge ref_clk) begin
        if (mon_on && !done)
            check(ref_pulse == (rt % 8 == 7), "R1 ref_pulse", int'(ref_pulse),
                  (rt % 8 == 7) ? 1 : 0);
    end

    initial begin
        repeat (20000) @(posedge vco_clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (6) @(posedge vco_clk);
        #2;
        // R7: reset state
        check(ref_pulse == 1'b0, "R7 ref_pulse in reset", int'(ref_pulse), 0);
        check(fb_pulse  == 1'b0, "R7 fb_pulse in reset",  int'(fb_pulse),  0);
        check(clk_out   == 1'b0, "R7 clk_out in reset",   int'(clk_out),   0);
        cur_eff = eff(5);
        last_tc = cur_eff - 1;
        fbq.push_back(last_tc);
        rst = 1'b0;
        mon_on = 1'b1;

        drive_m(5, 3, 0);
        n_cfg = 2'd1;
        drive_m(3, 4, 0);
        n_cfg = 2'd2;
        drive_m(2, 3, 0);
        drive_m(0, 3, 0);        // R3
        n_cfg = 2'd3;
        drive_m(1, 3, 0);        // R3
        drive_m(9, 2, 1);        // R4 mid-period change
        n_cfg = 2'd0;
        drive_m(4, 2, 3);        // R4 mid-period change
        n_cfg = 2'd2;
        drive_m(511, 2, 0);
        n_cfg = 2'd1;
        drive_m(6, 3, 0);

        while (t < last_tc + 3) begin
            @(posedge vco_clk); #2;
        end
        check(fbq.size() == 0, "R2 all fb pulses seen", fbq.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule